// File: doc/BRIEF.md
# Condition-Code Branch Resolver

This block decides the outcome of a branch that tests one of several floating-point condition-code bits. A decode stage presents a 5-bit branch selector, a signed 16-bit word offset, the address of the branch, a flag that says whether the branch itself occupies a delay slot, and the current condition-code vector. One cycle later the block reports whether the branch is taken, the address to fetch next, whether the delay-slot instruction must be annulled, and whether the encoding is illegal in its position.

The upper three selector bits pick one condition code. The lowest bit gives the sense, branch on true or on false. The next bit marks the "likely" form, which annuls the delay slot when the branch falls through. A second decision path applies the same condition test to an integer conditional move. It returns either the move source or the unchanged destination, with a write flag. Fetching and running the delay-slot instruction belong to the pipeline around the block.

Top module: `cc_branch_resolver`

## Requirements
- R1: Every cycle with `inValid` high is followed, one clock later, by exactly one cycle with `outValid` high. With no strobe, `outValid` is low.
- R2: A synchronous reset (`rst` high at a clock edge) leaves `outValid`, `illegal`, `taken` and `nullifySlot` low.
- R3: The condition code tested is `ccBits[brField[4:2]]` for branches and `ccBits[movField[4:2]]` for moves. Code index 0 is `ccBits[0]`.
- R4: `brField[1:0]` encodes the branch kind: 0 = branch if false, 1 = branch if true, 2 = branch if false (likely), 3 = branch if true (likely). The branch condition holds when the selected code equals `brField[0]`.
- R5: When `inDelaySlot` is high, the result has `illegal` = 1, `taken` = 0 and `nullifySlot` = 0, and `nextPc` equals the branch address. This holds whatever the condition codes are.
- R6: When the branch is legal and its condition holds, the result has `taken` = 1, `nullifySlot` = 0 and `nextPc` = `pcIn` + 4 + (sign-extended `brOffset` shifted left by 2).
- R7: A legal likely branch whose condition fails gives `taken` = 0, `nullifySlot` = 1 and `nextPc` = `pcIn` + 8.
- R8: A legal ordinary branch whose condition fails gives `taken` = 0, `nullifySlot` = 0 and `nextPc` = `pcIn` + 4.
- R9: When the move's selected code equals `movField[0]`, the result has `movWrite` = 1 and `movResult` = `movSrc`. Otherwise it has `movWrite` = 0 and `movResult` = `movDst`. Neither `inDelaySlot` nor the branch fields affect this result.
- R10: In cycles without a strobe, `nextPc`, `movResult`, `taken`, `nullifySlot`, `illegal` and `movWrite` keep their last values.
- R11: Target arithmetic wraps modulo 2^32. Negative offsets and addresses near the top of the space therefore give wrapped targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Strobe: the inputs hold a branch/move to resolve |
| brField | input | 5 | Branch selector: code index [4:2], likely [1], sense [0] |
| brOffset | input | 16 | Signed word offset of the branch |
| pcIn | input | 32 | Address of the branch instruction |
| inDelaySlot | input | 1 | The branch itself sits in a delay slot |
| ccBits | input | 8 | Condition-code vector |
| movField | input | 5 | Move selector: code index [4:2], sense [0] |
| movSrc | input | 32 | Move source value |
| movDst | input | 32 | Current destination value |
| outValid | output | 1 | Result valid, one cycle after the strobe |
| taken | output | 1 | Branch taken |
| nextPc | output | 32 | Next fetch address |
| nullifySlot | output | 1 | Annul the delay-slot instruction |
| illegal | output | 1 | Branch is illegal in a delay slot |
| movResult | output | 32 | Value for the move destination |
| movWrite | output | 1 | The move condition held |

## Verification
Random selectors, offsets and code vectors reach all eight codes with both senses and both forms. This separates a wrong code index from a wrong sense or a swapped likely bit. Directed cases place a set code beside a clear one, so a shifted index changes the outcome. They also drive a delay-slot branch whose condition would hold, to show that the illegal path beats the taken path. Further cases use the most negative offset and an address near the top of the space, which expose missing sign extension or a truncated sum. Idle cycles between strobes show whether the outputs hold.

// File: rtl/ccbr_pkg.sv
`timescale 1ns/1ps
package ccbr_pkg;

  typedef enum logic [1:0] {
    KIND_ON_FALSE    = 2'd0,
    KIND_ON_TRUE     = 2'd1,
    KIND_ON_FALSE_LK = 2'd2,
    KIND_ON_TRUE_LK  = 2'd3
  } brKind_e;

  typedef struct packed {
    logic capture;
    logic illegal;
    logic takeBranch;
    logic nullify;
    logic movCopy;
  } ctrlStrobe_t;

endpackage

// File: rtl/ccbr_ctrl.sv
`timescale 1ns/1ps
module ccbr_ctrl
  import ccbr_pkg::*;
#(
  parameter int CC_N    = 8,
  parameter int SEL_W   = $clog2(CC_N),
  parameter int FIELD_W = SEL_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic               inDelaySlot,
  input  logic [FIELD_W-1:0] brField,
  input  logic [FIELD_W-1:0] movField,
  input  logic [CC_N-1:0]    ccBits,
  output ctrlStrobe_t        strobe,
  output logic               outValid,
  output logic               taken,
  output logic               nullifySlot,
  output logic               illegal
);

  logic [SEL_W-1:0] brSel;
  logic [SEL_W-1:0] movSel;
  logic [CC_N-1:0]  brHit;
  logic [CC_N-1:0]  movHit;
  logic             brCode;
  logic             movCode;
  brKind_e          brKind;
  logic             wantTrue;
  logic             isLikely;
  logic             condMet;

  assign brSel  = brField[FIELD_W-1:2];
  assign movSel = movField[FIELD_W-1:2];

  for (genvar g = 0; g < CC_N; g++) begin : g_ccSelect
    assign brHit[g]  = (brSel  == SEL_W'(g)) && ccBits[g];
    assign movHit[g] = (movSel == SEL_W'(g)) && ccBits[g];
  end

  assign brCode  = |brHit;
  assign movCode = |movHit;

  always_comb begin
    brKind   = brKind_e'(brField[1:0]);
    wantTrue = (brKind == KIND_ON_TRUE) || (brKind == KIND_ON_TRUE_LK);
    isLikely = (brKind == KIND_ON_FALSE_LK) || (brKind == KIND_ON_TRUE_LK);
    condMet  = (brCode == wantTrue);
  end

  always_comb begin
    strobe.capture    = inValid;
    strobe.illegal    = inDelaySlot;
    strobe.takeBranch = !inDelaySlot && condMet;
    strobe.nullify    = !inDelaySlot && !condMet && isLikely;
    strobe.movCopy    = (movCode == movField[0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid    <= 1'b0;
      taken       <= 1'b0;
      nullifySlot <= 1'b0;
      illegal     <= 1'b0;
    end else begin
      outValid <= inValid;
      if (strobe.capture) begin
        taken       <= strobe.takeBranch;
        nullifySlot <= strobe.nullify;
        illegal     <= strobe.illegal;
      end
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_valid_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  assert_reset_clears_R2: assert property (@(posedge clk)
    rst |=> (!outValid && !illegal && !taken && !nullifySlot));
  assert_illegal_no_branch_R5: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!taken && !nullifySlot));
  assert_nullify_not_taken_R7: assert property (@(posedge clk) disable iff (rst)
    nullifySlot |-> !taken);
  assert_ds_gives_illegal_R5: assert property (@(posedge clk) disable iff (rst)
    (inValid && inDelaySlot) |=> illegal);
  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(taken) && $stable(nullifySlot) && $stable(illegal)));

endmodule

// File: rtl/ccbr_datapath.sv
`timescale 1ns/1ps
module ccbr_datapath
  import ccbr_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int OFS_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [OFS_W-1:0]  brOffset,
  input  logic [DATA_W-1:0] movSrc,
  input  logic [DATA_W-1:0] movDst,
  output logic [PC_W-1:0]   nextPc,
  output logic [DATA_W-1:0] movResult,
  output logic              movWrite
);

  localparam int WORD_SHIFT = 2;
  localparam int EXT_W      = PC_W - OFS_W - WORD_SHIFT;
  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

  logic [PC_W-1:0] offsetBytes;
  logic [PC_W-1:0] fallPc;
  logic [PC_W-1:0] skipPc;
  logic [PC_W-1:0] targetPc;
  logic [PC_W-1:0] pcSel;

  assign offsetBytes = {{EXT_W{brOffset[OFS_W-1]}}, brOffset, {WORD_SHIFT{1'b0}}};
  assign fallPc      = pcIn + INSN_BYTES;
  assign skipPc      = fallPc + INSN_BYTES;
  assign targetPc    = fallPc + offsetBytes;

  always_comb begin
    if (strobe.illegal)         pcSel = pcIn;
    else if (strobe.takeBranch) pcSel = targetPc;
    else if (strobe.nullify)    pcSel = skipPc;
    else                        pcSel = fallPc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nextPc    <= '0;
      movResult <= '0;
      movWrite  <= 1'b0;
    end else if (strobe.capture) begin
      nextPc    <= pcSel;
      movResult <= strobe.movCopy ? movSrc : movDst;
      movWrite  <= strobe.movCopy;
    end
  end

  assert_taken_target_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && strobe.takeBranch) |=>
      (nextPc == $past(pcIn) + INSN_BYTES + {{EXT_W{$past(brOffset[OFS_W-1])}}, $past(brOffset), 2'b00}));
  assert_likely_skip_R7: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && strobe.nullify) |=> (nextPc == $past(pcIn) + PC_W'(8)));
  assert_illegal_pc_R5: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && strobe.illegal) |=> (nextPc == $past(pcIn)));
  assert_move_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && !strobe.movCopy) |=> (movResult == $past(movDst) && !movWrite));
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !strobe.capture |=> ($stable(nextPc) && $stable(movResult) && $stable(movWrite)));

endmodule

// File: rtl/cc_branch_resolver.sv
`timescale 1ns/1ps
module cc_branch_resolver
  import ccbr_pkg::*;
#(
  parameter int CC_N   = 8,
  parameter int PC_W   = 32,
  parameter int OFS_W  = 16,
  parameter int DATA_W = 32,
  localparam int SEL_W   = $clog2(CC_N),
  localparam int FIELD_W = SEL_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [FIELD_W-1:0] brField,
  input  logic [OFS_W-1:0]   brOffset,
  input  logic [PC_W-1:0]    pcIn,
  input  logic               inDelaySlot,
  input  logic [CC_N-1:0]    ccBits,
  input  logic [FIELD_W-1:0] movField,
  input  logic [DATA_W-1:0]  movSrc,
  input  logic [DATA_W-1:0]  movDst,
  output logic               outValid,
  output logic               taken,
  output logic [PC_W-1:0]    nextPc,
  output logic               nullifySlot,
  output logic               illegal,
  output logic [DATA_W-1:0]  movResult,
  output logic               movWrite
);

  ctrlStrobe_t strobe;

  ccbr_ctrl #(
    .CC_N (CC_N)
  ) i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .inValid     (inValid),
    .inDelaySlot (inDelaySlot),
    .brField     (brField),
    .movField    (movField),
    .ccBits      (ccBits),
    .strobe      (strobe),
    .outValid    (outValid),
    .taken       (taken),
    .nullifySlot (nullifySlot),
    .illegal     (illegal)
  );

  ccbr_datapath #(
    .PC_W   (PC_W),
    .OFS_W  (OFS_W),
    .DATA_W (DATA_W)
  ) i_datapath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .pcIn      (pcIn),
    .brOffset  (brOffset),
    .movSrc    (movSrc),
    .movDst    (movDst),
    .nextPc    (nextPc),
    .movResult (movResult),
    .movWrite  (movWrite)
  );

endmodule

// File: tb/test_cc_branch_resolver.sv
`timescale 1ns/1ps
module test_cc_branch_resolver;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [4:0]  brField = '0;
  logic [15:0] brOffset = '0;
  logic [31:0] pcIn = '0;
  logic        inDelaySlot = 1'b0;
  logic [7:0]  ccBits = '0;
  logic [4:0]  movField = '0;
  logic [31:0] movSrc = '0;
  logic [31:0] movDst = '0;
  logic        outValid, taken, nullifySlot, illegal, movWrite;
  logic [31:0] nextPc, movResult;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cc_branch_resolver i_cc_branch_resolver (
    .clk(clk), .rst(rst), .inValid(inValid), .brField(brField), .brOffset(brOffset),
    .pcIn(pcIn), .inDelaySlot(inDelaySlot), .ccBits(ccBits), .movField(movField),
    .movSrc(movSrc), .movDst(movDst), .outValid(outValid), .taken(taken),
    .nextPc(nextPc), .nullifySlot(nullifySlot), .illegal(illegal),
    .movResult(movResult), .movWrite(movWrite)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string branchReq(logic ds, logic [4:0] f, logic [7:0] cc);
    if (ds) return "R5";
    if (cc[f[4:2]] == f[0]) return "R6";
    if (f[1]) return "R7";
    return "R8";
  endfunction

  function automatic logic [31:0] expPc(logic ds, logic [4:0] f, logic [15:0] ofs,
                                        logic [31:0] pc, logic [7:0] cc);
    if (ds) return pc;
    if (cc[f[4:2]] == f[0]) return pc + 32'd4 + {{14{ofs[15]}}, ofs, 2'b00};
    if (f[1]) return pc + 32'd8;
    return pc + 32'd4;
  endfunction

  task automatic resolve(logic [4:0] f, logic [15:0] ofs, logic [31:0] pc, logic ds,
                         logic [7:0] cc, logic [4:0] mf, logic [31:0] src, logic [31:0] dst);
    string req;
    logic  cond, mc;
    logic [31:0] pcExp, movExp;
    @(negedge clk);
    brField = f; brOffset = ofs; pcIn = pc; inDelaySlot = ds; ccBits = cc;
    movField = mf; movSrc = src; movDst = dst; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    req   = branchReq(ds, f, cc);
    cond  = !ds && (cc[f[4:2]] == f[0]);
    pcExp = expPc(ds, f, ofs, pc, cc);
    mc    = (cc[mf[4:2]] == mf[0]);
    movExp = mc ? src : dst;
    check("R1", "outValid", 32'(outValid), 32'd1);
    check(req, "taken R4", 32'(taken), 32'(cond));
    check(req, "illegal", 32'(illegal), 32'(ds));
    check(req, "nullify", 32'(nullifySlot), 32'(!ds && !cond && f[1]));
    check(req, "nextPc R11", nextPc, pcExp);
    check("R9", "movResult R3", movResult, movExp);
    check("R9", "movWrite", 32'(movWrite), 32'(mc));
    // scramble inputs without a strobe: outputs must hold
    brField = ~f; pcIn = ~pc; movSrc = ~src; movDst = ~dst; ccBits = ~cc; inDelaySlot = !ds;
    @(negedge clk);
    check("R1", "outValid idle", 32'(outValid), 32'd0);
    check("R10", "nextPc hold", nextPc, pcExp);
    check("R10", "taken hold", 32'(taken), 32'(cond));
    check("R10", "movResult hold", movResult, movExp);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2", "outValid reset", 32'(outValid), 32'd0);
    check("R2", "illegal reset", 32'(illegal), 32'd0);
    check("R2", "taken reset", 32'(taken), 32'd0);
    rst = 1'b0;

    // R3: code 5 set, neighbours clear; branch-if-true on 5, 4, 6
    resolve({3'd5, 2'd1}, 16'h0010, 32'h0000_1000, 1'b0, 8'b0010_0000, {3'd5, 2'd1}, 32'hAAAA_0001, 32'h5555_0001);
    resolve({3'd4, 2'd1}, 16'h0010, 32'h0000_1000, 1'b0, 8'b0010_0000, {3'd4, 2'd1}, 32'hAAAA_0002, 32'h5555_0002);
    resolve({3'd6, 2'd1}, 16'h0010, 32'h0000_1000, 1'b0, 8'b0010_0000, {3'd6, 2'd0}, 32'hAAAA_0003, 32'h5555_0003);
    // R4 all four kinds on a clear code 0
    for (int k = 0; k < 4; k++)
      resolve({3'd0, 2'(k)}, 16'h0004, 32'h0000_2000, 1'b0, 8'hFE, {3'd0, 2'(k)}, 32'h1, 32'h2);
    // R5: in a delay slot with a holding condition, likely and ordinary
    resolve({3'd7, 2'd3}, 16'h0100, 32'h0000_3000, 1'b1, 8'h80, {3'd7, 2'd1}, 32'h3, 32'h4);
    resolve({3'd2, 2'd0}, 16'h0100, 32'h0000_3000, 1'b1, 8'h00, {3'd2, 2'd0}, 32'h5, 32'h6);
    // R11: most negative offset, and wrap past the top of the space
    resolve({3'd1, 2'd1}, 16'h8000, 32'h0000_0010, 1'b0, 8'h02, {3'd1, 2'd1}, 32'h7, 32'h8);
    resolve({3'd3, 2'd0}, 16'h7FFF, 32'hFFFF_FFF0, 1'b0, 8'h00, {3'd3, 2'd1}, 32'h9, 32'hA);
    resolve({3'd3, 2'd2}, 16'h0001, 32'hFFFF_FFFC, 1'b0, 8'h08, {3'd3, 2'd0}, 32'hB, 32'hC);

    for (int i = 0; i < 400; i++) begin
      logic ds;
      ds = ($urandom % 8) == 0;
      resolve(5'($urandom), 16'($urandom), {$urandom, 2'b00} , ds, 8'($urandom),
              5'($urandom), $urandom, $urandom);
    end

    // R2: reset mid-run clears result flags
    resolve({3'd0, 2'd0}, 16'h0, 32'h100, 1'b1, 8'h00, 5'd0, 32'h0, 32'h0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R2", "illegal after reset", 32'(illegal), 32'd0);
    check("R2", "outValid after reset", 32'(outValid), 32'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule